// File: doc/BRIEF.md
# EDID DDC Read Engine

This block fetches one 128-byte block of display identification data from a sink over a two-wire DDC bus. The bus runs without host involvement. A host writes a clock divider, a segment number and a starting word address through a small byte-wide register port. Writing the word address starts the fetch. The engine then produces the complete bus sequence: an optional segment pointer write, the word address write, a repeated start and a sequential read of 128 bytes. It acknowledges every byte except the last one. It NACKs the last byte and then issues a stop condition.

Received bytes go into an internal FIFO that holds one full block. They leave the block on a valid/ready byte stream. A byte is presented while `edid_valid` is high and is consumed on a clock edge where `edid_ready` is also high. While `edid_ready` is low, the byte on `edid_data` stays put. Because the FIFO holds a whole block, back-pressure on the stream never slows the DDC bus. A completion flag can be routed to an interrupt line through a mask bit. A sink that does not acknowledge a write byte aborts the fetch and raises an error flag.

The bus pins are open-drain: each output, when high, pulls its line low. SDA is read back through `ddc_sda_in`. The engine does not stretch SCL, does not arbitrate with other masters and does not issue general writes.

Top module: `edid_fetch_engine`

## Requirements
- R1: Register offsets 0 and 1 hold the low and high bytes of a 16-bit divider DIV. Every SCL quarter period lasts DIV+1 clocks, so each SCL high phase of a data bit lasts exactly 2*(DIV+1) clocks.
- R2: Writing offset 3 (word address) while idle starts a fetch. The engine reads 128 bytes from the sink starting at that word address, and they come out of the stream in bus order.
- R3: Offset 2 holds the segment number. When it is nonzero, the engine sends a write to 7-bit address 0x30 carrying the segment before the word address write to 7-bit address 0x50. When it is zero, no transaction to address 0x30 occurs.
- R4: The master ACKs each of the first 127 read bytes and NACKs the 128th, then issues exactly one stop condition per fetch.
- R5: The FIFO is emptied when a fetch starts. The stream holds `edid_data` stable while valid is high and ready is low. A full block can be held with ready low, and it then drains completely with no bytes lost.
- R6: Status offset 4, bit 0 (ready) is set when a fetch completes without error. Writing 1 to that bit clears it.
- R7: `irq` is high exactly when status bit 0 is set and bit 0 of the mask register at offset 5 is 1.
- R8: A NACK on any byte the engine writes aborts the fetch with a stop condition and sets status bit 1 (NACK error), which is cleared by writing 1. Status bit 0 stays clear in this case.
- R9: Status bit 2 (busy) is high from the start of a fetch until its stop condition ends. A word address write while busy is ignored: the register keeps its value and the running fetch continues unchanged.
- R10: After reset, status and mask read 0, `irq` and `edid_valid` are low, and both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` |
| irq | output | 1 | Completion interrupt |
| edid_valid | output | 1 | Stream byte available |
| edid_data | output | 8 | Stream byte |
| edid_ready | input | 1 | Consumer accepts the stream byte |
| ddc_scl_low | output | 1 | Pull SCL low when high |
| ddc_sda_low | output | 1 | Pull SDA low when high |
| ddc_sda_in | input | 1 | Sampled SDA line level |

## Verification
A bus-level sink model answers at addresses 0x30 and 0x50. It returns bytes computed arithmetically from the segment and address, so a wrong segment, a wrong start offset or a dropped or duplicated byte each change every value compared after them. Fetches are run with and without a segment, from both half-block offsets and at several divider values, and with the stream drained in parallel, drained after the fetch, or only partly drained before a new start. These cases separate FIFO clearing from back-pressure handling. The sink also counts master ACKs and NACKs, stop conditions and SCL high widths. A variant with the data address disabled exercises the abort path, the error flag and its clearing.

// File: rtl/edid_ddc_pkg.sv
package edid_ddc_pkg;

  typedef enum logic [1:0] {
    SYM_START,
    SYM_BIT,
    SYM_STOP
  } ddc_sym_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_START,
    C_TX,
    C_RX,
    C_STOP
  } ctrl_state_e;

  typedef enum logic [2:0] {
    P_SEGDEV,
    P_SEGVAL,
    P_DEVWR,
    P_WORD,
    P_DEVRD,
    P_DATA
  } fetch_phase_e;

  localparam int DIV_W = 16;
  localparam logic [6:0] SEG_DEV_ADDR  = 7'h30;
  localparam logic [6:0] EDID_DEV_ADDR = 7'h50;

  localparam logic [2:0] OFS_DIV_LO = 3'd0;
  localparam logic [2:0] OFS_DIV_HI = 3'd1;
  localparam logic [2:0] OFS_SEG    = 3'd2;
  localparam logic [2:0] OFS_WORD   = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_MASK   = 3'd5;

endpackage

// File: rtl/ddc_quarter_tick.sv
module ddc_quarter_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = (cnt >= div) && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ddc_bit_phy.sv
module ddc_bit_phy
  import edid_ddc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     go,
  input  ddc_sym_e sym,
  input  logic     tx_bit,
  input  logic     sda_in,
  output logic     done,
  output logic     rx_bit,
  output logic     scl_low,
  output logic     sda_low
);

  logic     active;
  logic [1:0] q;
  ddc_sym_e sym_q;
  logic     bit_q;

  // returns {scl_low, sda_low} for a symbol and quarter
  function automatic logic [1:0] lines(input ddc_sym_e s, input logic [1:0] qq, input logic b);
    logic [1:0] r;
    case (s)
      SYM_START: begin
        case (qq)
          2'd0:    r = 2'b10;
          2'd1:    r = 2'b00;
          2'd2:    r = 2'b01;
          default: r = 2'b11;
        endcase
      end
      SYM_STOP: begin
        case (qq)
          2'd0:    r = 2'b11;
          2'd1:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      default: begin
        r = {(qq == 2'd0 || qq == 2'd3), !b};
      end
    endcase
    return r;
  endfunction

  assign done   = active && tick && (q == 2'd3);
  assign rx_bit = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      q       <= 2'd0;
      sym_q   <= SYM_START;
      bit_q   <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else if (go) begin
      active             <= 1'b1;
      q                  <= 2'd0;
      sym_q              <= sym;
      bit_q              <= tx_bit;
      {scl_low, sda_low} <= lines(sym, 2'd0, tx_bit);
    end else if (active && tick) begin
      if (q == 2'd2) begin
        bit_q <= sda_in;
      end
      if (q == 2'd3) begin
        active <= 1'b0;
      end else begin
        q                  <= q + 1'b1;
        {scl_low, sda_low} <= lines(sym_q, q + 1'b1, bit_q);
      end
    end
  end

  AST_SCL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_low) |-> $past(tick || go)); // R1

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && sym_q == SYM_BIT) |-> $stable(sda_low)); // R2

endmodule

// File: rtl/edid_fifo.sv
module edid_fifo #(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       push,
  input  logic [7:0] push_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, pop, wr_en;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready && !clear;
  assign wr_en     = push && !full && !clear;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      case ({wr_en, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_data))); // R5

endmodule

// File: rtl/edid_fetch_ctrl.sv
module edid_fetch_ctrl
  import edid_ddc_pkg::*;
#(
  parameter int BLOCK_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] seg_in,
  input  logic [7:0] word_in,
  input  logic       phy_done,
  input  logic       rx_bit,
  output logic       phy_go,
  output ddc_sym_e   phy_sym,
  output logic       phy_bit,
  output logic       push,
  output logic [7:0] push_data,
  output logic       fetch_ok,
  output logic       fetch_nack,
  output logic       busy
);

  localparam int BCW = $clog2(BLOCK_BYTES);
  localparam logic [BCW-1:0] LAST = BCW'(BLOCK_BYTES - 1);

  ctrl_state_e    state;
  fetch_phase_e   phase;
  logic           waiting;
  logic [3:0]     bitcnt;
  logic [7:0]     sh;
  logic [BCW-1:0] bytecnt;
  logic [7:0]     seg_q, word_q;
  logic           nack_seen;
  logic [7:0]     txb;

  always_comb begin
    case (phase)
      P_SEGDEV: txb = {SEG_DEV_ADDR, 1'b0};
      P_SEGVAL: txb = seg_q;
      P_DEVWR:  txb = {EDID_DEV_ADDR, 1'b0};
      P_WORD:   txb = word_q;
      P_DEVRD:  txb = {EDID_DEV_ADDR, 1'b1};
      default:  txb = 8'hFF;
    endcase
  end

  always_comb begin
    case (state)
      C_START: phy_sym = SYM_START;
      C_STOP:  phy_sym = SYM_STOP;
      default: phy_sym = SYM_BIT;
    endcase
    if (state == C_TX) begin
      phy_bit = (bitcnt == 4'd8) ? 1'b1 : txb[3'd7 - bitcnt[2:0]];
    end else if (state == C_RX) begin
      phy_bit = (bitcnt == 4'd8) ? (bytecnt == LAST) : 1'b1;
    end else begin
      phy_bit = 1'b1;
    end
  end

  assign busy       = (state != C_IDLE);
  assign phy_go     = busy && !waiting;
  assign push       = (state == C_RX) && phy_done && (bitcnt == 4'd8);
  assign push_data  = sh;
  assign fetch_ok   = (state == C_STOP) && phy_done && !nack_seen;
  assign fetch_nack = (state == C_STOP) && phy_done && nack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= C_IDLE;
      phase     <= P_DEVWR;
      waiting   <= 1'b0;
      bitcnt    <= 4'd0;
      sh        <= 8'h00;
      bytecnt   <= '0;
      seg_q     <= 8'h00;
      word_q    <= 8'h00;
      nack_seen <= 1'b0;
    end else if (start && !busy) begin
      state     <= C_START;
      phase     <= (seg_in != 8'h00) ? P_SEGDEV : P_DEVWR;
      seg_q     <= seg_in;
      word_q    <= word_in;
      waiting   <= 1'b0;
      bitcnt    <= 4'd0;
      bytecnt   <= '0;
      nack_seen <= 1'b0;
    end else begin
      if (phy_go) begin
        waiting <= 1'b1;
      end
      if (phy_done) begin
        waiting <= 1'b0;
        case (state)
          C_START: begin
            state  <= C_TX;
            bitcnt <= 4'd0;
          end
          C_TX: begin
            if (bitcnt != 4'd8) begin
              bitcnt <= bitcnt + 1'b1;
            end else begin
              bitcnt <= 4'd0;
              if (rx_bit) begin
                nack_seen <= 1'b1;
                state     <= C_STOP;
              end else begin
                case (phase)
                  P_SEGDEV: phase <= P_SEGVAL;
                  P_SEGVAL: begin phase <= P_DEVWR; state <= C_START; end
                  P_DEVWR:  phase <= P_WORD;
                  P_WORD:   begin phase <= P_DEVRD; state <= C_START; end
                  default:  begin phase <= P_DATA; state <= C_RX; end
                endcase
              end
            end
          end
          C_RX: begin
            if (bitcnt != 4'd8) begin
              bitcnt <= bitcnt + 1'b1;
              sh     <= {sh[6:0], rx_bit};
            end else begin
              bitcnt <= 4'd0;
              if (bytecnt == LAST) begin
                state <= C_STOP;
              end else begin
                bytecnt <= bytecnt + 1'b1;
              end
            end
          end
          default: state <= C_IDLE;
        endcase
      end
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R9

  AST_OK_XOR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_ok && fetch_nack)); // R8

endmodule

// File: rtl/edid_fetch_engine.sv
module edid_fetch_engine
  import edid_ddc_pkg::*;
#(
  parameter int BLOCK_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       edid_valid,
  output logic [7:0] edid_data,
  input  logic       edid_ready,
  output logic       ddc_scl_low,
  output logic       ddc_sda_low,
  input  logic       ddc_sda_in
);

  logic [DIV_W-1:0] div_q;
  logic [7:0]       seg_q, word_q;
  logic             mask_q, st_ready, st_nack;
  logic             busy, start, tick;
  logic             phy_go, phy_bit, phy_done, rx_bit;
  ddc_sym_e         phy_sym;
  logic             push, fetch_ok, fetch_nack;
  logic [7:0]       push_data;
  logic             wr_status;

  assign start     = reg_wr && (reg_addr == OFS_WORD) && !busy;
  assign wr_status = reg_wr && (reg_addr == OFS_STATUS);
  assign irq       = st_ready && mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      seg_q    <= 8'h00;
      word_q   <= 8'h00;
      mask_q   <= 1'b0;
      st_ready <= 1'b0;
      st_nack  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_DIV_LO) div_q[7:0]  <= reg_wdata;
      if (reg_wr && reg_addr == OFS_DIV_HI) div_q[15:8] <= reg_wdata;
      if (reg_wr && reg_addr == OFS_SEG)    seg_q       <= reg_wdata;
      if (reg_wr && reg_addr == OFS_MASK)   mask_q      <= reg_wdata[0];
      if (start)                            word_q      <= reg_wdata;
      if (fetch_ok)                         st_ready <= 1'b1;
      else if (wr_status && reg_wdata[0])   st_ready <= 1'b0;
      if (fetch_nack)                       st_nack  <= 1'b1;
      else if (wr_status && reg_wdata[1])   st_nack  <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_DIV_LO: reg_rdata = div_q[7:0];
      OFS_DIV_HI: reg_rdata = div_q[15:8];
      OFS_SEG:    reg_rdata = seg_q;
      OFS_WORD:   reg_rdata = word_q;
      OFS_STATUS: reg_rdata = {5'b0, busy, st_nack, st_ready};
      OFS_MASK:   reg_rdata = {7'b0, mask_q};
      default:    reg_rdata = 8'h00;
    endcase
  end

  ddc_quarter_tick #(.W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phy_go),
    .div   (div_q),
    .tick  (tick)
  );

  ddc_bit_phy u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .go      (phy_go),
    .sym     (phy_sym),
    .tx_bit  (phy_bit),
    .sda_in  (ddc_sda_in),
    .done    (phy_done),
    .rx_bit  (rx_bit),
    .scl_low (ddc_scl_low),
    .sda_low (ddc_sda_low)
  );

  edid_fetch_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seg_in     (seg_q),
    .word_in    (reg_wdata),
    .phy_done   (phy_done),
    .rx_bit     (rx_bit),
    .phy_go     (phy_go),
    .phy_sym    (phy_sym),
    .phy_bit    (phy_bit),
    .push       (push),
    .push_data  (push_data),
    .fetch_ok   (fetch_ok),
    .fetch_nack (fetch_nack),
    .busy       (busy)
  );

  edid_fifo #(.DEPTH(BLOCK_BYTES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .push      (push),
    .push_data (push_data),
    .out_valid (edid_valid),
    .out_data  (edid_data),
    .out_ready (edid_ready)
  );

  AST_READY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ready) |-> !busy); // R6

endmodule

// File: tb/edid_fetch_engine_test.sv
module edid_fetch_engine_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       edid_valid;
  logic [7:0] edid_data;
  logic       edid_ready = 1'b0;
  logic       ddc_scl_low, ddc_sda_low;
  logic       scl_line, sda_line;
  logic       s_drive = 1'b0;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  assign scl_line = !ddc_scl_low;
  assign sda_line = !(ddc_sda_low | s_drive);

  edid_fetch_engine uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .edid_valid  (edid_valid),
    .edid_data   (edid_data),
    .edid_ready  (edid_ready),
    .ddc_scl_low (ddc_scl_low),
    .ddc_sda_low (ddc_sda_low),
    .ddc_sda_in  (sda_line)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  function automatic logic [7:0] edid_byte(input logic [7:0] s, input logic [7:0] a);
    logic [7:0] t;
    t = a * 8'd7 + 8'd29;
    return t ^ (s * 8'd41);
  endfunction

  // ---------------- sink model ----------------
  bit         seg_en = 1'b1, edid_en = 1'b1;
  logic       s_on = 1'b0, s_seen = 1'b0, s_rx = 1'b1, s_first = 1'b0;
  logic       s_nak = 1'b0, s_rw = 1'b0, s_mack = 1'b0;
  int         s_bit = 0;
  logic [7:0] s_sh = 8'h00, s_tx = 8'h00;
  logic [1:0] s_sel = 2'd0;
  logic [7:0] seg_ptr = 8'h00, word_ptr = 8'h00;
  int         seg_acks = 0, mack_n = 0, mnack_n = 0, stop_n = 0;
  int         hi_run = 0, last_hi = 0;

  always @(negedge sda_line) begin
    if (scl_line === 1'b1) begin
      s_on = 1'b1; s_seen = 1'b1; s_bit = -1; s_first = 1'b1; s_rx = 1'b1; s_drive = 1'b0;
    end
  end

  always @(posedge sda_line) begin
    if (scl_line === 1'b1 && s_seen) begin
      stop_n++;
      s_seen = 1'b0; s_on = 1'b0; s_drive = 1'b0; seg_ptr = 8'h00;
    end
  end

  always @(posedge scl_line) begin
    if (s_on && s_bit >= 0) begin
      if (s_bit < 8) begin
        if (s_rx) s_sh = {s_sh[6:0], sda_line};
      end else if (!s_rx) begin
        if (sda_line == 1'b0) begin s_mack = 1'b1; mack_n++; end
        else begin s_mack = 1'b0; mnack_n++; end
      end
    end
  end

  always @(negedge scl_line) begin
    if (s_on) begin
      if (s_bit == 7) begin
        s_bit = 8;
        if (s_rx) begin
          if (s_first) begin
            s_rw = s_sh[0]; s_nak = 1'b1;
            if (s_sh[7:1] == 7'h30 && seg_en) begin s_sel = 2'd1; s_nak = 1'b0; seg_acks++; end
            else if (s_sh[7:1] == 7'h50 && edid_en) begin s_sel = 2'd2; s_nak = 1'b0; end
          end else begin
            s_nak = 1'b0;
            if (s_sel == 2'd1) seg_ptr = s_sh; else word_ptr = s_sh;
          end
          s_drive = !s_nak;
        end else begin
          s_drive = 1'b0;
        end
      end else if (s_bit == 8) begin
        s_drive = 1'b0; s_bit = 0;
        if (s_rx) begin
          if (s_nak) s_on = 1'b0;
          else if (s_first) begin
            s_first = 1'b0;
            if (s_rw) begin
              s_rx = 1'b0; s_tx = edid_byte(seg_ptr, word_ptr); word_ptr++; s_drive = !s_tx[7];
            end
          end
        end else if (s_mack) begin
          s_tx = edid_byte(seg_ptr, word_ptr); word_ptr++; s_drive = !s_tx[7];
        end else begin
          s_on = 1'b0;
        end
      end else begin
        s_bit++;
        if (!s_rx) s_drive = !s_tx[7 - s_bit];
      end
    end
  end

  always @(negedge clk) begin
    if (scl_line) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] st;
    int g = 0;
    st = 8'h04;
    while (st[2] && g < 60000) begin rd(3'd4, st); g++; end
    if (g >= 60000) check_eq({req, " timeout"}, 1, 0);
  endtask

  task automatic drain(input int n, input logic [7:0] sg, input logic [7:0] wd, input string req);
    int got = 0;
    int g = 0;
    while (got < n && g < 60000) begin
      @(negedge clk);
      edid_ready = 1'b1;
      g++;
      if (edid_valid) begin
        check_eq(req, int'(edid_data), int'(edid_byte(sg, 8'(wd + got))));
        got++;
      end
    end
    @(negedge clk);
    edid_ready = 1'b0;
    if (got < n) check_eq({req, " byte count"}, got, n);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(3'd4, d); check_eq("R10 status", d, 0);
    rd(3'd5, d); check_eq("R10 mask", d, 0);
    check_eq("R10 irq", irq, 0);
    check_eq("R10 valid", edid_valid, 0);
    check_eq("R10 bus", {scl_line, sda_line}, 2'b11);

    // Fetch A: segment 0, word 0x00, DIV=1, drained while running
    wr(3'd0, 8'd1); wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    mack_n = 0; mnack_n = 0; stop_n = 0; seg_acks = 0;
    wr(3'd3, 8'h00);
    rd(3'd4, d); check_eq("R9 busy after start", d[2], 1);
    wr(3'd3, 8'h80);
    rd(3'd3, d); check_eq("R9 word write ignored", d, 8'h00);
    drain(128, 8'd0, 8'h00, "R2 fetch A data");
    wait_idle("R9 fetch A");
    rd(3'd4, d); check_eq("R6 ready after A", d, 8'h01);
    check_eq("R7 irq masked", irq, 0);
    check_eq("R3 no segment write", seg_acks, 0);
    check_eq("R4 acks", mack_n, 127);
    check_eq("R4 final nack", mnack_n, 1);
    check_eq("R4 stops", stop_n, 1);
    check_eq("R1 scl high DIV=1", last_hi, 4);
    check_eq("R5 fifo empty after A", edid_valid, 0);

    // R7 / R6 interrupt mask and W1C
    wr(3'd5, 8'h01);
    check_eq("R7 irq unmasked", irq, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, d); check_eq("R6 ready cleared", d, 0);
    check_eq("R7 irq after clear", irq, 0);

    // Fetch B: segment 1, word 0x80, DIV=2, held under back-pressure
    wr(3'd0, 8'd2); wr(3'd2, 8'd1);
    stop_n = 0;
    wr(3'd3, 8'h80);
    wait_idle("R9 fetch B");
    check_eq("R3 segment write sent", seg_acks, 1);
    check_eq("R7 irq on B", irq, 1);
    check_eq("R1 scl high DIV=2", last_hi, 6);
    check_eq("R4 stops B", stop_n, 1);
    check_eq("R5 valid held", edid_valid, 1);
    drain(128, 8'd1, 8'h80, "R5 fetch B held block");
    check_eq("R5 fifo empty after B", edid_valid, 0);
    wr(3'd4, 8'h01);

    // Fetch C1 partly drained, then C2 must start from an empty FIFO
    wr(3'd0, 8'd0); wr(3'd2, 8'd2);
    wr(3'd3, 8'h10);
    wait_idle("R9 fetch C1");
    drain(5, 8'd2, 8'h10, "R3 fetch C1 segment 2");
    check_eq("R5 leftover present", edid_valid, 1);
    wr(3'd2, 8'd0);
    wr(3'd3, 8'h80);
    check_eq("R5 cleared at start", edid_valid, 0);
    wait_idle("R9 fetch C2");
    drain(128, 8'd0, 8'h80, "R5 fetch C2 data");
    check_eq("R5 fifo empty after C2", edid_valid, 0);
    wr(3'd4, 8'h01);

    // NACK abort
    edid_en = 1'b0; stop_n = 0;
    wr(3'd3, 8'h00);
    wait_idle("R8 abort");
    rd(3'd4, d); check_eq("R8 nack status", d, 8'h02);
    check_eq("R8 stop on abort", stop_n, 1);
    check_eq("R8 no data", edid_valid, 0);
    check_eq("R7 no irq on abort", irq, 0);
    wr(3'd4, 8'h02);
    rd(3'd4, d); check_eq("R8 nack cleared", d, 0);
    edid_en = 1'b1;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule